// File: doc/BRIEF.md
# Dual-Channel Capture/Compare Timer

The block holds a free-running up-counter and two general registers, called A and B. Each general register has its own 3-bit mode field. The top bit of the field selects how the register works. As an output compare register, it drives an output pin low, drives it high or toggles it when the counter reaches the register's value. As an input capture register, it latches the counter when a chosen edge arrives on a capture input. Capture inputs are asynchronous. They pass through a two-flop synchroniser before any edge is detected.

All registers are reached through a simple single-cycle bus that uses byte addresses. A write takes effect at the next clock edge. Read data is combinational from the current register state. A standby request clears the mode register, so both channels return to a quiet, pin-low state.

Top module: `cct_timer`

## Requirements
- R1: The mode register is 8 bits at byte address 0. Bits 2:0 hold the mode of register A and bits 6:4 hold the mode of register B. Bits 7 and 3 always read 0, and writing them has no effect.
- R2: While `rst` is high, the mode register, counter and pins reset to 0 and both general registers reset to 0xFFFF. A cycle with `stby` high clears only the mode register to 0x00.
- R3: The counter rises by one on every clock and wraps from 0xFFFF to 0x0000. A bus write to byte address 6 loads it instead of the increment.
- R4: Mode 000 makes the register a compare register whose pin is held at 0 regardless of any match.
- R5: A match is the cycle in which the counter equals the register. Mode 001 drives the pin to 0 and mode 010 drives it to 1 at the clock edge that ends the match cycle.
- R6: Mode 011 inverts the pin once for each match, at the clock edge that ends the match cycle.
- R7: In any mode with the top bit set (100 to 111), the pin reads 0. Mode 100 loads nothing on any input edge.
- R8: Mode 101 captures on a rising edge of the channel input, mode 110 on a falling edge, and mode 111 on both. The value captured is the counter value two clocks after the cycle in which the input changed, and it is readable three clocks after that change.
- R9: A bus write to a general register wins over a capture in the same clock edge.
- R10: Byte addresses 0, 2, 4 and 6 select the mode register, register A, register B and the counter. Writes to odd addresses are ignored. Read data reflects the selected register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stby | input | 1 | Standby request; clears the mode register |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cap_a | input | 1 | Capture input of register A |
| cap_b | input | 1 | Capture input of register B |
| pin_a | output | 1 | Compare output of register A |
| pin_b | output | 1 | Compare output of register B |

## Verification
The assertions assume the following about the inputs:
- Once the synchroniser has settled, each capture input changes at most once per clock.
- No bus write reaches a register that the check in question observes in the same cycle, except where the write-priority rule itself is checked.

The stimulus stays within these limits:
- It changes capture inputs only at falling edges.
- It leaves several idle clocks between edges.
- It places every compare value well ahead of the running counter, so no match happens before the counter is reloaded on purpose.

// File: rtl/cct_pkg.sv
package cct_pkg;

    localparam int CTRL_W = 8;
    localparam logic [CTRL_W-1:0] CTRL_MASK = 8'h77;

    typedef enum logic [2:0] {
        MD_OFF    = 3'b000,
        MD_CLR    = 3'b001,
        MD_SET    = 3'b010,
        MD_TGL    = 3'b011,
        MD_CAPOFF = 3'b100,
        MD_RISE   = 3'b101,
        MD_FALL   = 3'b110,
        MD_BOTH   = 3'b111
    } gr_mode_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_GRA  = 2'd1,
        SEL_GRB  = 2'd2,
        SEL_CNT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic is_capture(input gr_mode_e m);
        return m[2];
    endfunction

    function automatic logic edge_hit(input gr_mode_e m, input edge_t e);
        case (m)
            MD_RISE: return e.rise;
            MD_FALL: return e.fall;
            MD_BOTH: return e.rise | e.fall;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cct_edge_sync.sv
module cct_edge_sync
    import cct_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output edge_t edges
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign edges.rise = s2_q & ~s3_q;
    assign edges.fall = ~s2_q & s3_q;

    // R8
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        edges.rise |-> $past(s1_q));

endmodule

// File: rtl/cct_channel.sv
module cct_channel
    import cct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  gr_mode_e     mode,
    input  logic [W-1:0] cnt,
    input  logic         cap_in,
    input  logic         gr_wr,
    input  logic [W-1:0] gr_wdata,
    output logic [W-1:0] gr,
    output logic         pin
);
    edge_t edges;
    logic  match;
    logic  cap_hit;
    logic  pin_q;
    logic [W-1:0] gr_q;

    cct_edge_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (cap_in),
        .edges (edges)
    );

    assign match   = !is_capture(mode) && (cnt == gr_q);
    assign cap_hit = edge_hit(mode, edges);

    always_ff @(posedge clk) begin
        if (rst)          gr_q <= '1;
        else if (gr_wr)   gr_q <= gr_wdata;
        else if (cap_hit) gr_q <= cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else begin
            case (mode)
                MD_CLR:  if (match) pin_q <= 1'b0;
                MD_SET:  if (match) pin_q <= 1'b1;
                MD_TGL:  if (match) pin_q <= ~pin_q;
                default: pin_q <= 1'b0;
            endcase
        end
    end

    assign gr  = gr_q;
    assign pin = pin_q;

    // R4
    off_low_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_OFF) |=> !pin);

    // R5
    set_match_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_SET && cnt == gr) |=> pin);

    // R5
    clr_match_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_CLR && cnt == gr) |=> !pin);

    // R6
    tgl_match_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_TGL && cnt == gr) |=> (pin != $past(pin)));

    // R7
    cap_pin_low_chk: assert property (@(posedge clk) disable iff (rst)
        mode[2] |=> !pin);

    // R8
    cap_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_hit && !gr_wr) |=> (gr == $past(cnt)));

    // R9
    wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
        gr_wr |=> (gr == $past(gr_wdata)));

    // R7
    cap_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_CAPOFF && !gr_wr) |=> $stable(gr));

endmodule

// File: rtl/cct_timer.sv
module cct_timer
    import cct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stby,
    input  logic         bus_wr,
    input  logic [2:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         cap_a,
    input  logic         cap_b,
    output logic         pin_a,
    output logic         pin_b
);
    localparam int NCH = 2;

    reg_sel_e           sel;
    logic               wr_ok;
    logic [CTRL_W-1:0]  ctrl_q;
    logic [W-1:0]       cnt_q;
    gr_mode_e           mode  [NCH];
    logic [W-1:0]       gr    [NCH];
    logic [NCH-1:0]     cap_v;
    logic [NCH-1:0]     pin_v;

    assign sel   = reg_sel_e'(bus_addr[2:1]);
    assign wr_ok = bus_wr && !bus_addr[0];
    assign cap_v = {cap_b, cap_a};

    always_ff @(posedge clk) begin
        if (rst || stby)                     ctrl_q <= '0;
        else if (wr_ok && sel == SEL_CTRL)   ctrl_q <= bus_wdata[CTRL_W-1:0] & CTRL_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst)                             cnt_q <= '0;
        else if (wr_ok && sel == SEL_CNT)    cnt_q <= bus_wdata;
        else                                 cnt_q <= cnt_q + 1'b1;
    end

    assign mode[0] = gr_mode_e'(ctrl_q[2:0]);
    assign mode[1] = gr_mode_e'(ctrl_q[6:4]);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam reg_sel_e MY_SEL = (g == 0) ? SEL_GRA : SEL_GRB;
        cct_channel #(.W(W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .mode     (mode[g]),
            .cnt      (cnt_q),
            .cap_in   (cap_v[g]),
            .gr_wr    (wr_ok && sel == MY_SEL),
            .gr_wdata (bus_wdata),
            .gr       (gr[g]),
            .pin      (pin_v[g])
        );
    end

    always_comb begin
        case (sel)
            SEL_CTRL: bus_rdata = {{(W-CTRL_W){1'b0}}, ctrl_q};
            SEL_GRA:  bus_rdata = gr[0];
            SEL_GRB:  bus_rdata = gr[1];
            default:  bus_rdata = cnt_q;
        endcase
    end

    assign pin_a = pin_v[0];
    assign pin_b = pin_v[1];

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_ok && sel == SEL_CNT) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R2
    stby_clear_chk: assert property (@(posedge clk) disable iff (rst)
        stby |=> (ctrl_q == '0));

    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && sel == SEL_CTRL && !stby) |=>
            (ctrl_q[7] == 1'b0 && ctrl_q[3] == 1'b0 && ctrl_q[2:0] == $past(bus_wdata[2:0])));

endmodule

// File: tb/tb_cct_timer.sv
module tb_cct_timer;
    import cct_pkg::*;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         stby = 1'b0;
    logic         bus_wr = 1'b0;
    logic [2:0]   bus_addr = 3'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         cap_a = 1'b0, cap_b = 1'b0;
    logic         pin_a, pin_b;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cct_timer #(.W(W)) dut (
        .clk(clk), .rst(rst), .stby(stby), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_a(cap_a), .cap_b(cap_b),
        .pin_a(pin_a), .pin_b(pin_b)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic pin_of(input int ch);
        return (ch == 0) ? pin_a : pin_b;
    endfunction

    task automatic set_cap(input int ch, input logic v);
        if (ch == 0) cap_a = v; else cap_b = v;
    endtask

    // Write mode, compare value G, then counter G-3: the match cycle comes
    // three clocks later and the pin updates one clock after that.
    task automatic cmp_run(input int ch, input logic [2:0] code, input logic [W-1:0] g,
                           input logic exp_before, input logic exp_after, input string req);
        wr(3'd0, W'(code) << (4 * ch));
        wr(3'(2 + 2 * ch), g);
        wr(3'd6, g - 16'd3);
        repeat (3) @(negedge clk);
        check(req, W'(pin_of(ch)), W'(exp_before));
        @(negedge clk);
        check(req, W'(pin_of(ch)), W'(exp_after));
        repeat (4) @(negedge clk);
        check(req, W'(pin_of(ch)), W'(exp_after));
    endtask

    initial begin
        logic [W-1:0] v, d, prev;
        repeat (3) @(negedge clk);
        // R2: reset state
        rd(3'd0, d); check("R2 ctrl", d, 16'h0000);
        rd(3'd2, d); check("R2 gra", d, 16'hFFFF);
        rd(3'd4, d); check("R2 grb", d, 16'hFFFF);
        rd(3'd6, d); check("R2 cnt", d, 16'h0000);
        check("R2 pins", W'({pin_b, pin_a}), 16'h0);
        rst = 1'b0;

        // R3: counting and wrap
        @(negedge clk);
        rd(3'd6, v);
        repeat (5) @(negedge clk);
        rd(3'd6, d); check("R3 step", d, v + 16'd5);
        wr(3'd6, 16'hFFFE);
        rd(3'd6, d); check("R3 load", d, 16'hFFFE);
        repeat (2) @(negedge clk);
        rd(3'd6, d); check("R3 wrap", d, 16'h0000);

        // R1 / R10: reserved bits and map, odd address ignored
        wr(3'd0, 16'hFFFF);
        rd(3'd0, d); check("R1 rsvd", d, 16'h0077);
        wr(3'd1, 16'h0011);
        rd(3'd0, d); check("R10 odd", d, 16'h0077);
        wr(3'd2, 16'h1357);
        wr(3'd4, 16'h2468);
        rd(3'd2, d); check("R10 gra", d, 16'h1357);
        rd(3'd4, d); check("R10 grb", d, 16'h2468);
        // R7: capture modes hold pins low
        check("R7 pins", W'({pin_b, pin_a}), 16'h0);

        // R2: standby clears the mode register only
        @(negedge clk); stby = 1'b1;
        @(negedge clk); stby = 1'b0;
        rd(3'd0, d); check("R2 stby", d, 16'h0000);
        rd(3'd2, d); check("R2 stby gra", d, 16'h1357);

        for (int ch = 0; ch < 2; ch++) begin
            // R5, R6, R4 compare sweep
            cmp_run(ch, 3'b010, 16'h4000, 1'b0, 1'b1, "R5 set");
            cmp_run(ch, 3'b001, 16'h4100, 1'b1, 1'b0, "R5 clr");
            cmp_run(ch, 3'b011, 16'h4200, 1'b0, 1'b1, "R6 tgl");
            cmp_run(ch, 3'b011, 16'h4300, 1'b1, 1'b0, "R6 tgl2");
            cmp_run(ch, 3'b010, 16'h4400, 1'b0, 1'b1, "R5 set2");
            cmp_run(ch, 3'b000, 16'h4500, 1'b0, 1'b0, "R4 off");

            // R7 / R8 capture sweep over codes and edge directions
            for (int code = 4; code < 8; code++) begin
                wr(3'd0, W'(code) << (4 * ch));
                wr(3'(2 + 2 * ch), 16'h1234);
                prev = 16'h1234;
                for (int e = 0; e < 2; e++) begin
                    logic hit;
                    hit = (code == 7) || (code == 5 && e == 0) || (code == 6 && e == 1);
                    rd(3'd6, v);
                    set_cap(ch, (e == 0));
                    repeat (3) @(negedge clk);
                    rd(3'(2 + 2 * ch), d);
                    if (hit) prev = v + 16'd2;
                    check(code == 4 ? "R7 capoff" : "R8 capture", d, prev);
                    check("R7 pin", W'(pin_of(ch)), 16'h0);
                    repeat (3) @(negedge clk);
                end
            end

            // R9: write in the same edge as a capture wins
            wr(3'd0, W'(5) << (4 * ch));
            set_cap(ch, 1'b1);
            repeat (2) @(negedge clk);
            bus_wr = 1'b1; bus_addr = 3'(2 + 2 * ch); bus_wdata = 16'hABCD;
            @(negedge clk);
            bus_wr = 1'b0;
            rd(3'(2 + 2 * ch), d); check("R9 prio", d, 16'hABCD);
            repeat (2) @(negedge clk);
            rd(3'(2 + 2 * ch), d); check("R9 hold", d, 16'hABCD);
            set_cap(ch, 1'b0);
            wr(3'd0, 16'h0000);
            repeat (4) @(negedge clk);
        end
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule